// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block lets an on-chip register port run transfers on an external 8-bit or 16-bit parallel peripheral bus. A write of the data register makes the block put that value on the bus in a write cycle. A read request of the data register makes it fetch a fresh value in a read cycle. Read requests are read-ahead: the value seen on `data_out` after the request is the result of that cycle, once it completes. The block sequences the address phases, the address-latch strobe, the read and write strobes and two chip selects. It reports a busy flag and can pulse an interrupt line when a cycle finishes.

Four address/data multiplexing modes trade pin count against cycle length:

- address on its own pins;
- low address byte multiplexed onto the data lines;
- address sent over the data lines as two byte phases;
- address sent over the data lines as one full-width phase.

Setup, strobe and hold wait states stretch a cycle. Each strobe and each chip select has its own polarity. The address can step by one after every transfer. Busy drops in the final clock of a cycle, so software that polls it can start the next transfer back-to-back with no idle clock.

Top module: `pmb_master`

## Requirements
- R1: `wr_en` starts a write cycle and `rd_en` starts a read cycle, but only when `busy` is 0. `wr_en` wins if both are high. A request made while `busy` is 1 is ignored: it adds no cycle and leaves `data_out` unchanged.
- R2: With all waits zero, the cycle length in clocks (the clocks a selected chip select is active) depends on `mux_mode` as follows:
  - 00: read 2, write 3
  - 01: read 5, write 6
  - 10: read 8, write 9
  - 11: read 5, write 6
- R3: Each address phase lasts 3 clocks. Mode 00 has none, modes 01 and 11 have one and mode 10 has two. The waits add to the R2 length as follows:
  - `wait_setup` adds clocks before the strobe;
  - the strobe is active for 1+`wait_strobe` clocks;
  - `wait_hold` adds clocks after the strobe.
- R4: `busy` rises in the first clock of a cycle and is high for length-1 clocks; it is low in the cycle's last clock. A request made in that last clock starts the next cycle with no gap, and the chip select stays active across both cycles.
- R5: `bus_ale` pulses once per address phase, in its middle clock, with `bus_ad_oe` high. The value on `bus_ad` during the pulse depends on the mode (masked address per R7):
  - mode 01: low address byte on `bus_ad[7:0]`;
  - mode 10: low byte in the first pulse, then high byte in the second, both on `bus_ad[7:0]`;
  - mode 11: the whole masked address.
- R6: `bus_addr` carries the masked address in mode 00 and only its upper byte in mode 01, and is 0 in modes 10 and 11. `addr_hi_en`=0 zeroes bits 15:8 of the address and `addr_lo_en`=0 zeroes bits 7:0.
- R7: With `cs_func`=10, address bit 15 selects `bus_cs2` and bit 14 selects `bus_cs1`. The selected chip select is held active for the whole cycle, and both bits read 0 in the driven address. With any other `cs_func` neither chip select is ever active and all address bits are driven.
- R8: A polarity input of 0 makes its pin active-low and 1 makes it active-high, separately for `bus_rd`, `bus_wr`, `bus_cs1` and `bus_cs2`. Idle pins sit at the inactive level.
- R9: `rd_pin_en`=0 or `wr_pin_en`=0 keeps that strobe inactive while cycle length and chip selects are unchanged. The two strobes are never active together.
- R10: A read loads `bus_din` into `data_out` on the edge where the read strobe ends. With `wide`=1 all 16 bits are kept; with `wide`=0 the value is `bus_din[7:0]` zero-extended.
- R11: During a write's data phases `bus_ad` carries the written value with `bus_ad_oe` high. With `wide`=0 the value is zero-extended from `wr_data[7:0]`.
- R12: With `auto_inc`=1 the address register increments by one at the end of every cycle. An `addr_ld` accepted in the same clock takes priority.
- R13: With `irq_mode`=01, `irq` is high for exactly one clock, the clock after each cycle's last clock. With other `irq_mode` values `irq` stays 0.
- R14: After reset:
  - `busy`, `irq`, `bus_ale`, `bus_ad_oe` and `data_out` are 0;
  - all strobes and chip selects are at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Data register write; starts a write cycle |
| wr_data | input | 16 | Value written to the data register |
| rd_en | input | 1 | Data register read; starts a read cycle |
| data_out | output | 16 | Data register contents |
| addr_ld | input | 1 | Load the address register |
| addr_in | input | 16 | Address to load |
| mux_mode | input | 2 | Address/data multiplexing mode |
| wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| wait_setup | input | 2 | Setup wait clocks |
| wait_strobe | input | 4 | Extra strobe clocks |
| wait_hold | input | 2 | Hold wait clocks |
| rd_pol | input | 1 | Read strobe polarity (0 active-low) |
| wr_pol | input | 1 | Write strobe polarity (0 active-low) |
| cs1_pol | input | 1 | Chip select 1 polarity (0 active-low) |
| cs2_pol | input | 1 | Chip select 2 polarity (0 active-low) |
| rd_pin_en | input | 1 | Read strobe output enable |
| wr_pin_en | input | 1 | Write strobe output enable |
| cs_func | input | 2 | 10 = chip selects from address bits 15/14 |
| addr_hi_en | input | 1 | Drive address bits 15:8 |
| addr_lo_en | input | 1 | Drive address bits 7:0 |
| auto_inc | input | 1 | Increment address after each cycle |
| irq_mode | input | 2 | 01 = interrupt pulse per cycle |
| bus_din | input | 16 | Data read from the external bus |
| bus_ad | output | 16 | Multiplexed address/data lines |
| bus_ad_oe | output | 1 | Output enable for bus_ad |
| bus_addr | output | 16 | Dedicated address pins |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe pin |
| bus_wr | output | 1 | Write strobe pin |
| bus_cs1 | output | 1 | Chip select 1 pin |
| bus_cs2 | output | 1 | Chip select 2 pin |
| busy | output | 1 | Cycle in progress (low in last clock) |
| irq | output | 1 | End-of-cycle pulse |

## Verification
The bench measures every mode with and without wait states. A design that miscounts a phase shows a chip-select window of the wrong length, or a strobe or ALE count that does not match. The bench then starts a second transfer in the very clock where busy falls. A controller whose busy drops too late leaves a gap, one that drops too early truncates the cycle, and one that accepts a request while busy lengthens the cycle or corrupts the data register. Masking of the chip-select address bits, byte ordering across the two address phases, 8-bit zero-extension, polarity inversion, strobe disabling and address increment are each probed on their own. Each of these faults then shows up as a wrong pin value rather than hiding behind the timing.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADR1, PH_ADR2, PH_SETUP, PH_STRB, PH_TAIL
  } phase_t;

  localparam logic [1:0] MUX_NONE = 2'b00;
  localparam logic [1:0] MUX_HALF = 2'b01;
  localparam logic [1:0] MUX_TWO  = 2'b10;
  localparam logic [1:0] MUX_FULL = 2'b11;
  localparam logic [1:0] CS_ADDR  = 2'b10;
  localparam logic [1:0] IRQ_EACH = 2'b01;
endpackage

// File: rtl/pmb_seq.sv
module pmb_seq
  import pmb_pkg::*;
#(
  parameter int WS_W  = 2,
  parameter int WM_W  = 4,
  parameter int WH_W  = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [1:0]       mode,
  input  logic [WS_W-1:0]  wait_setup,
  input  logic [WM_W-1:0]  wait_strobe,
  input  logic [WH_W-1:0]  wait_hold,
  output phase_t           phase_d,
  output logic [CNT_W-1:0] cnt_d,
  output logic             wr_d,
  output logic             busy,
  output logic             done,
  output logic             cap
);
  phase_t           phase_q;
  phase_t           nx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] setup_n;
  logic             wr_q;
  logic             accept;

  function automatic phase_t after(phase_t p, logic [1:0] m, logic has_setup);
    phase_t data_first;
    data_first = has_setup ? PH_SETUP : PH_STRB;
    case (p)
      PH_IDLE:  return (m == MUX_NONE) ? data_first : PH_ADR1;
      PH_ADR1:  return (m == MUX_TWO) ? PH_ADR2 : data_first;
      PH_ADR2:  return data_first;
      PH_SETUP: return PH_STRB;
      PH_STRB:  return PH_TAIL;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] span(phase_t p, logic [CNT_W-1:0] su,
                                            logic [WM_W-1:0] wm, logic [WH_W-1:0] wh);
    case (p)
      PH_ADR1, PH_ADR2: return CNT_W'(2);
      PH_SETUP:         return su - 1'b1;
      PH_STRB:          return CNT_W'(wm);
      PH_TAIL:          return CNT_W'(wh);
      default:          return '0;
    endcase
  endfunction

  always_comb begin
    accept  = start && !busy;
    wr_d    = accept ? start_wr : wr_q;
    setup_n = CNT_W'(wait_setup) + CNT_W'(wr_d);
    phase_d = phase_q;
    cnt_d   = cnt_q;
    nx      = PH_IDLE;
    if (accept) begin
      nx      = after(PH_IDLE, mode, setup_n != '0);
      phase_d = nx;
      cnt_d   = span(nx, setup_n, wait_strobe, wait_hold);
    end else if (phase_q != PH_IDLE) begin
      if (cnt_q == '0) begin
        nx      = after(phase_q, mode, setup_n != '0);
        phase_d = nx;
        cnt_d   = span(nx, setup_n, wait_strobe, wait_hold);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    done = (phase_q == PH_TAIL) && (cnt_q == '0);
    cap  = (phase_q == PH_STRB) && (cnt_q == '0) && !wr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      busy    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      busy    <= (phase_d != PH_IDLE) && !((phase_d == PH_TAIL) && (cnt_d == '0));
    end
  end

  // R4: busy is low exactly in the final clock of a cycle
  p_busy_last_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_TAIL && cnt_q == '0) |-> !busy);
  // R4: busy is high through every earlier clock of a cycle
  p_busy_mid_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && !(phase_q == PH_TAIL && cnt_q == '0)) |-> busy);
endmodule

// File: rtl/pmb_pins.sv
module pmb_pins
  import pmb_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             wr_d,
  input  logic [1:0]       mode,
  input  logic [BUS_W-1:0] addr_d,
  input  logic [BUS_W-1:0] data_d,
  input  logic [1:0]       cs_func,
  input  logic             addr_hi_en,
  input  logic             addr_lo_en,
  input  logic             rd_pin_en,
  input  logic             wr_pin_en,
  output logic [BUS_W-1:0] ad,
  output logic             ad_oe,
  output logic [BUS_W-1:0] addr_pins,
  output logic             ale,
  output logic             rd_act,
  output logic             wr_act,
  output logic             cs1_act,
  output logic             cs2_act
);
  localparam int HALF = BUS_W / 2;

  logic [BUS_W-1:0] ma;
  logic [BUS_W-1:0] ad_n;
  logic [BUS_W-1:0] ap_n;
  logic             in_adr;
  logic             in_data;
  logic             cs_on;

  always_comb begin
    ma = addr_d;
    if (cs_func == CS_ADDR) ma[BUS_W-1 -: 2] = 2'b00;
    if (!addr_hi_en) ma[BUS_W-1:HALF] = '0;
    if (!addr_lo_en) ma[HALF-1:0] = '0;
    in_adr  = (phase_d == PH_ADR1) || (phase_d == PH_ADR2);
    in_data = (phase_d == PH_SETUP) || (phase_d == PH_STRB) || (phase_d == PH_TAIL);
    cs_on   = (phase_d != PH_IDLE) && (cs_func == CS_ADDR);
    ad_n    = '0;
    if (phase_d == PH_ADR1)
      ad_n = (mode == MUX_FULL) ? ma : {{HALF{1'b0}}, ma[HALF-1:0]};
    else if (phase_d == PH_ADR2)
      ad_n = {{HALF{1'b0}}, ma[BUS_W-1:HALF]};
    else if (in_data && wr_d)
      ad_n = data_d;
    case (mode)
      MUX_NONE: ap_n = ma;
      MUX_HALF: ap_n = {ma[BUS_W-1:HALF], {HALF{1'b0}}};
      default:  ap_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad        <= '0;
      ad_oe     <= 1'b0;
      addr_pins <= '0;
      ale       <= 1'b0;
      rd_act    <= 1'b0;
      wr_act    <= 1'b0;
      cs1_act   <= 1'b0;
      cs2_act   <= 1'b0;
    end else begin
      ad        <= ad_n;
      ad_oe     <= in_adr || (in_data && wr_d);
      addr_pins <= ap_n;
      ale       <= in_adr && (cnt_d == CNT_W'(1));
      rd_act    <= (phase_d == PH_STRB) && !wr_d && rd_pin_en;
      wr_act    <= (phase_d == PH_STRB) && wr_d && wr_pin_en;
      cs1_act   <= cs_on && addr_d[BUS_W-2];
      cs2_act   <= cs_on && addr_d[BUS_W-1];
    end
  end

  // R9: the two strobes never overlap
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(rd_act && wr_act));
  // R5: the latch strobe only appears while the block drives the lines
  p_ale_driven_r5: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe);
endmodule

// File: rtl/pmb_addr.sv
module pmb_addr #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [BUS_W-1:0] ld_val,
  input  logic             inc,
  output logic [BUS_W-1:0] addr_q,
  output logic [BUS_W-1:0] addr_d
);
  always_comb begin
    if (ld)       addr_d = ld_val;
    else if (inc) addr_d = addr_q + 1'b1;
    else          addr_d = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr_d;
  end
endmodule

// File: rtl/pmb_master.sv
module pmb_master
  import pmb_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int WS_W  = 2,
  parameter int WM_W  = 4,
  parameter int WH_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [BUS_W-1:0] data_out,
  input  logic             addr_ld,
  input  logic [BUS_W-1:0] addr_in,
  input  logic [1:0]       mux_mode,
  input  logic             wide,
  input  logic [WS_W-1:0]  wait_setup,
  input  logic [WM_W-1:0]  wait_strobe,
  input  logic [WH_W-1:0]  wait_hold,
  input  logic             rd_pol,
  input  logic             wr_pol,
  input  logic             cs1_pol,
  input  logic             cs2_pol,
  input  logic             rd_pin_en,
  input  logic             wr_pin_en,
  input  logic [1:0]       cs_func,
  input  logic             addr_hi_en,
  input  logic             addr_lo_en,
  input  logic             auto_inc,
  input  logic [1:0]       irq_mode,
  input  logic [BUS_W-1:0] bus_din,
  output logic [BUS_W-1:0] bus_ad,
  output logic             bus_ad_oe,
  output logic [BUS_W-1:0] bus_addr,
  output logic             bus_ale,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_cs1,
  output logic             bus_cs2,
  output logic             busy,
  output logic             irq
);
  localparam int HALF  = BUS_W / 2;
  localparam int WMAX  = (WM_W > WS_W) ? ((WM_W > WH_W) ? WM_W : WH_W)
                                       : ((WS_W > WH_W) ? WS_W : WH_W);
  localparam int CNT_W = WMAX + 2;

  phase_t           phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             wr_d;
  logic             done;
  logic             cap;
  logic             start;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] addr_d;
  logic [BUS_W-1:0] data_d;
  logic             rd_act;
  logic             wr_act;
  logic             cs1_act;
  logic             cs2_act;

  assign start = wr_en || rd_en;

  pmb_seq #(.WS_W(WS_W), .WM_W(WM_W), .WH_W(WH_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_wr(wr_en), .mode(mux_mode),
    .wait_setup(wait_setup), .wait_strobe(wait_strobe), .wait_hold(wait_hold),
    .phase_d(phase_d), .cnt_d(cnt_d), .wr_d(wr_d), .busy(busy),
    .done(done), .cap(cap)
  );

  pmb_addr #(.BUS_W(BUS_W)) u_addr (
    .clk(clk), .rst(rst), .ld(addr_ld && !busy), .ld_val(addr_in),
    .inc(done && auto_inc), .addr_q(addr_q), .addr_d(addr_d)
  );

  always_comb begin
    data_d = data_out;
    if (wr_en && !busy)
      data_d = wide ? wr_data : {{HALF{1'b0}}, wr_data[HALF-1:0]};
    else if (cap)
      data_d = wide ? bus_din : {{HALF{1'b0}}, bus_din[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      irq      <= 1'b0;
    end else begin
      data_out <= data_d;
      irq      <= done && (irq_mode == IRQ_EACH);
    end
  end

  pmb_pins #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_pins (
    .clk(clk), .rst(rst), .phase_d(phase_d), .cnt_d(cnt_d), .wr_d(wr_d),
    .mode(mux_mode), .addr_d(addr_d), .data_d(data_d), .cs_func(cs_func),
    .addr_hi_en(addr_hi_en), .addr_lo_en(addr_lo_en),
    .rd_pin_en(rd_pin_en), .wr_pin_en(wr_pin_en),
    .ad(bus_ad), .ad_oe(bus_ad_oe), .addr_pins(bus_addr), .ale(bus_ale),
    .rd_act(rd_act), .wr_act(wr_act), .cs1_act(cs1_act), .cs2_act(cs2_act)
  );

  assign bus_rd  = rd_pol  ? rd_act  : ~rd_act;
  assign bus_wr  = wr_pol  ? wr_act  : ~wr_act;
  assign bus_cs1 = cs1_pol ? cs1_act : ~cs1_act;
  assign bus_cs2 = cs2_pol ? cs2_act : ~cs2_act;

  // R13: the completion pulse lasts a single clock
  p_irq_once_r13: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R7: chip selects do not move inside a cycle
  p_cs_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(bus_cs1) && $stable(bus_cs2)));
endmodule

// File: tb/pmb_master_tb.sv
module pmb_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, addr_ld = 1'b0;
  logic [15:0] wr_data = '0, addr_in = '0, bus_din = '0;
  logic [1:0]  mux_mode = 2'b00, cs_func = 2'b10, irq_mode = 2'b01;
  logic        wide = 1'b1;
  logic [1:0]  wait_setup = '0, wait_hold = '0;
  logic [3:0]  wait_strobe = '0;
  logic        rd_pol = 0, wr_pol = 0, cs1_pol = 0, cs2_pol = 0;
  logic        rd_pin_en = 1, wr_pin_en = 1, addr_hi_en = 1, addr_lo_en = 1, auto_inc = 0;
  logic [15:0] data_out, bus_ad, bus_addr;
  logic        bus_ad_oe, bus_ale, bus_rd, bus_wr, bus_cs1, bus_cs2, busy, irq;

  always #5 clk = ~clk;

  pmb_master u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .data_out(data_out), .addr_ld(addr_ld), .addr_in(addr_in),
    .mux_mode(mux_mode), .wide(wide), .wait_setup(wait_setup),
    .wait_strobe(wait_strobe), .wait_hold(wait_hold), .rd_pol(rd_pol),
    .wr_pol(wr_pol), .cs1_pol(cs1_pol), .cs2_pol(cs2_pol),
    .rd_pin_en(rd_pin_en), .wr_pin_en(wr_pin_en), .cs_func(cs_func),
    .addr_hi_en(addr_hi_en), .addr_lo_en(addr_lo_en), .auto_inc(auto_inc),
    .irq_mode(irq_mode), .bus_din(bus_din), .bus_ad(bus_ad),
    .bus_ad_oe(bus_ad_oe), .bus_addr(bus_addr), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_cs1(bus_cs1), .bus_cs2(bus_cs2),
    .busy(busy), .irq(irq)
  );

  int total = 0, bad = 0;
  int tick = 0, n_cs1 = 0, n_cs2 = 0, n_busy = 0, n_rd = 0, n_wr = 0, n_ale = 0, n_irq = 0;
  int irq_tick = 0;
  int b_tick, b_cs1, b_cs2, b_busy, b_rd, b_wr, b_ale, b_irq;
  logic        ale_prev = 1'b0;
  logic [15:0] ale_old = '0, ale_new = '0, strb_ad = '0, strb_addr = '0;

  always @(negedge clk) begin
    tick++;
    if (bus_cs1 == cs1_pol) n_cs1++;
    if (bus_cs2 == cs2_pol) n_cs2++;
    if (busy) n_busy++;
    if (bus_rd == rd_pol) begin n_rd++; strb_addr = bus_addr; end
    if (bus_wr == wr_pol) begin n_wr++; strb_ad = bus_ad; strb_addr = bus_addr; end
    if (bus_ale && !ale_prev) begin n_ale++; ale_old = ale_new; ale_new = bus_ad; end
    ale_prev = bus_ale;
    if (irq) begin n_irq++; irq_tick = tick; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    b_tick = tick; b_cs1 = n_cs1; b_cs2 = n_cs2; b_busy = n_busy;
    b_rd = n_rd; b_wr = n_wr; b_ale = n_ale; b_irq = n_irq;
  endtask

  task automatic op(input logic is_wr, input logic [15:0] d, input int win);
    @(negedge clk); wr_en = is_wr; rd_en = !is_wr; wr_data = d;
    @(posedge clk); #1; wr_en = 0; rd_en = 0; snap();
    repeat (win) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [15:0] a);
    @(negedge clk); addr_ld = 1; addr_in = a;
    @(posedge clk); #1; addr_ld = 0;
  endtask

  typedef struct packed {
    logic [1:0] mode; logic wr; logic [1:0] ws; logic [3:0] wm;
    logic [1:0] wh; logic [5:0] len; logic [1:0] nale;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'd0, 1'b0, 2'd0, 4'd0,  2'd0, 6'd2,  2'd0},
    '{2'd0, 1'b1, 2'd0, 4'd0,  2'd0, 6'd3,  2'd0},
    '{2'd1, 1'b0, 2'd0, 4'd0,  2'd0, 6'd5,  2'd1},
    '{2'd1, 1'b1, 2'd0, 4'd0,  2'd0, 6'd6,  2'd1},
    '{2'd2, 1'b0, 2'd0, 4'd0,  2'd0, 6'd8,  2'd2},
    '{2'd2, 1'b1, 2'd0, 4'd0,  2'd0, 6'd9,  2'd2},
    '{2'd3, 1'b0, 2'd0, 4'd0,  2'd0, 6'd5,  2'd1},
    '{2'd3, 1'b1, 2'd0, 4'd0,  2'd0, 6'd6,  2'd1},
    '{2'd0, 1'b0, 2'd1, 4'd2,  2'd1, 6'd6,  2'd0},
    '{2'd1, 1'b1, 2'd1, 4'd2,  2'd1, 6'd10, 2'd1},
    '{2'd2, 1'b0, 2'd3, 4'd15, 2'd3, 6'd29, 2'd2},
    '{2'd3, 1'b1, 2'd2, 4'd0,  2'd0, 6'd8,  2'd1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R14 reset state
    check("R14 idle pins", {28'd0, bus_rd, bus_wr, bus_cs1, bus_cs2}, 32'hF);
    check("R14 flags", {28'd0, busy, irq, bus_ale, bus_ad_oe}, 32'h0);
    check("R14 data_out", 32'(data_out), 32'h0);

    load(16'h5A3C);
    for (int i = 0; i < 12; i++) begin
      vec_t v;
      v = VEC[i];
      mux_mode = v.mode; wait_setup = v.ws; wait_strobe = v.wm; wait_hold = v.wh;
      bus_din = 16'h9D00 + 16'(i);
      op(v.wr, 16'hC3A0 + 16'(i), 40);
      check($sformatf("R2 R3 length v%0d", i), 32'(n_cs1 - b_cs1), 32'(v.len));
      check($sformatf("R4 busy v%0d", i), 32'(n_busy - b_busy), 32'(v.len) - 1);
      check($sformatf("R3 strobe v%0d", i),
            v.wr ? 32'(n_wr - b_wr) : 32'(n_rd - b_rd), 32'(v.wm) + 1);
      check($sformatf("R5 ale count v%0d", i), 32'(n_ale - b_ale), 32'(v.nale));
      check($sformatf("R13 irq v%0d", i), 32'(n_irq - b_irq), 32'd1);
      check($sformatf("R13 irq time v%0d", i), 32'(irq_tick - b_tick), 32'(v.len) + 1);
      if (v.wr) check($sformatf("R11 write data v%0d", i), 32'(strb_ad), 32'(16'hC3A0 + 16'(i)));
      else      check($sformatf("R10 read data v%0d", i), 32'(data_out), 32'(bus_din));
      case (v.mode)
        2'd0: check($sformatf("R6 addr v%0d", i), 32'(strb_addr), 32'h1A3C);
        2'd1: begin
          check($sformatf("R6 addr v%0d", i), 32'(strb_addr), 32'h1A00);
          check($sformatf("R5 ad v%0d", i), 32'(ale_new), 32'h003C);
        end
        2'd2: begin
          check($sformatf("R5 ad lo v%0d", i), 32'(ale_old), 32'h003C);
          check($sformatf("R5 ad hi v%0d", i), 32'(ale_new), 32'h001A);
        end
        default: check($sformatf("R5 ad full v%0d", i), 32'(ale_new), 32'h1A3C);
      endcase
    end

    mux_mode = 2'b00; wait_setup = 0; wait_strobe = 0; wait_hold = 0;
    // R10 and R11 narrow width
    wide = 0; bus_din = 16'hBEEF;
    op(0, 16'h0, 10);
    check("R10 narrow read", 32'(data_out), 32'h00EF);
    op(1, 16'h1234, 10);
    check("R11 narrow write", 32'(strb_ad), 32'h0034);
    wide = 1;

    // R6 pin enables
    addr_lo_en = 0; op(0, 16'h0, 10);
    check("R6 lower disabled", 32'(strb_addr), 32'h1A00);
    addr_lo_en = 1; addr_hi_en = 0; op(0, 16'h0, 10);
    check("R6 upper disabled", 32'(strb_addr), 32'h003C);
    addr_hi_en = 1;

    // R8 polarity
    rd_pol = 1; cs1_pol = 1; op(0, 16'h0, 10);
    check("R8 rd active high", 32'(n_rd - b_rd), 32'd1);
    check("R8 cs1 active high", 32'(n_cs1 - b_cs1), 32'd2);
    check("R8 rd idle level", 32'(bus_rd), 32'd0);
    rd_pol = 0; cs1_pol = 0;

    // R9 strobe disable
    wr_pin_en = 0; op(1, 16'h5555, 10);
    check("R9 wr disabled", 32'(n_wr - b_wr), 32'd0);
    check("R9 length kept", 32'(n_cs1 - b_cs1), 32'd3);
    wr_pin_en = 1;

    // R7 chip select 2 from bit 15
    load(16'h8001); op(0, 16'h0, 10);
    check("R7 cs2 count", 32'(n_cs2 - b_cs2), 32'd2);
    check("R7 cs1 idle", 32'(n_cs1 - b_cs1), 32'd0);

    // R7 no chip select function: full address driven
    cs_func = 2'b00; load(16'h5A3C); op(0, 16'h0, 10);
    check("R7 cs off", 32'(n_cs1 - b_cs1), 32'd0);
    check("R7 full addr", 32'(strb_addr), 32'h5A3C);

    // R12 auto increment
    auto_inc = 1; load(16'h0010);
    op(0, 16'h0, 10);
    check("R12 first addr", 32'(strb_addr), 32'h0010);
    op(0, 16'h0, 10);
    check("R12 second addr", 32'(strb_addr), 32'h0011);
    auto_inc = 0; cs_func = 2'b10; load(16'h5A3C);

    // R13 interrupt disabled
    irq_mode = 2'b00; op(1, 16'h0, 10);
    check("R13 irq off", 32'(n_irq - b_irq), 32'd0);
    irq_mode = 2'b01;

    // R1 request while busy is ignored
    mux_mode = 2'b10; bus_din = 16'h4321;
    @(negedge clk); rd_en = 1;
    @(posedge clk); #1; rd_en = 0; snap();
    repeat (3) @(negedge clk);
    wr_en = 1; wr_data = 16'h7777;
    @(posedge clk); #1; wr_en = 0;
    repeat (30) @(negedge clk);
    @(posedge clk); #1;
    check("R1 no extra cycle", 32'(n_cs1 - b_cs1), 32'd8);
    check("R1 no write strobe", 32'(n_wr - b_wr), 32'd0);
    check("R1 data kept", 32'(data_out), 32'h4321);

    // R4 back-to-back start in the last clock
    mux_mode = 2'b00;
    @(negedge clk); wr_en = 1; wr_data = 16'hA001;
    @(posedge clk); #1; wr_en = 0; snap();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    wr_en = 1; wr_data = 16'hA002;
    @(posedge clk); #1; wr_en = 0;
    repeat (12) @(negedge clk);
    @(posedge clk); #1;
    check("R4 b2b chip select", 32'(n_cs1 - b_cs1), 32'd6);
    check("R4 b2b busy", 32'(n_busy - b_busy), 32'd4);
    check("R4 b2b strobes", 32'(n_wr - b_wr), 32'd2);
    check("R13 b2b irq", 32'(n_irq - b_irq), 32'd2);
    check("R4 b2b second data", 32'(strb_ad), 32'hA002);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule